// File: doc/BRIEF.md
# SDRAM Open-Row Command Sequencer

This block turns single read and write requests from a host into command sequences for a two-bank synchronous DRAM. Each request carries a bank, row, column, byte mask and write data. The host holds it on a valid/acknowledge port until the controller takes it. The controller drives the chip-select, row-strobe, column-strobe and write-enable pins, plus the bank, address, byte-mask and data lines. Read data comes back to the host with a one-cycle valid strobe after the CAS latency.

A configuration input picks one of two modes.

- **Auto-precharge mode:** every access opens the row, issues a column command with the auto-precharge bit set, and leaves the bank closed.
- **Open-row mode:** the controller remembers one active row per bank. An access to that row (a hit) skips activation. An access to a different row (a miss) precharges that bank first. An access to a closed bank activates it directly.
  - A hit read is preceded by one idle cycle, so that the byte mask is already on the pins one cycle before the column command. This meets the two-cycle mask latency of reads.

The precharge-to-activate delay is selectable between one and two cycles. A refresh timer periodically closes all banks with a precharge-all command and then issues an auto refresh. The refresh period is kept at or below the longest time a row may stay active. Requests are held off while a refresh is pending or running.

Top module: `sdram_bank_ctrl`

## Requirements
- R1: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows, and cs_n is low on every command:
  - NOP 0111
  - activate 0011
  - read 0101
  - write 0100
  - precharge 0010
  - refresh 0001
  
  Address bit 10 is the auto-precharge bit on column commands and the all-banks bit on precharge. Out of reset the pins show NOP, the byte mask is all ones, the data output enable is low, and both banks are closed.
- R2: With open_row_i low, a request to a closed bank gives activate (address = row) one cycle after the acknowledge cycle. The column command follows T_RCD cycles later with address bit 10 high, and the bank is closed afterwards.
- R3: With open_row_i high, column commands carry address bit 10 low, and the bank stays open on the accessed row.
- R4: In open-row mode, a write hit puts the write command in the cycle after the acknowledge, with no activate.
- R5: In open-row mode, a read hit puts a NOP in the cycle after the acknowledge and the read command in the cycle after that. On every read, sd_dqm_o equals the request mask both in the read-command cycle and in the cycle before it.
- R6: A request to an open bank whose row differs, or any request to an open bank while open_row_i is low, gives a single-bank precharge (bit 10 low) in the cycle after the acknowledge. Activate follows after the precharge delay, and the column command T_RCD cycles after activate.
- R7: trp_sel_i low gives a precharge-to-activate (and precharge-all-to-refresh) spacing of 1 cycle; high gives 2 cycles.
- R8: In open-row mode, a request to a closed bank gives activate in the cycle after the acknowledge, with no precharge, even when the other bank is open.
- R9: After a write with auto precharge, the next request is acknowledged no earlier than T_RWL+T_AP+1 cycles after the write command. After an open-row write, a waiting request is acknowledged in the cycle right after the write command.
- R10: Read data sampled from sd_dq_i CAS_LAT cycles after the read command appears on rd_data_o with rd_valid_o high for exactly one cycle, CAS_LAT+1 cycles after the read command.
- R11: In the write-command cycle, sd_dq_o carries the request data, sd_dq_oe_o is high and sd_dqm_o carries the request mask. sd_dq_oe_o is low in every other cycle.
- R12: Every REF_INTERVAL cycles a precharge-all (bit 10 high) is issued, followed by refresh after the precharge delay. Both banks are closed afterwards, so the next access activates without a precharge. No request is acknowledged between the refresh becoming due and the end of the refresh wait.
- R13: req_ack_o is high only in a cycle where req_valid_i is high and the controller is idle, and it is never high two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| open_row_i | input | 1 | 1: open-row mode, 0: auto-precharge mode |
| trp_sel_i | input | 1 | Precharge delay select: 0 = 1 cycle, 1 = 2 cycles |
| req_valid_i | input | 1 | Request valid, held until acknowledged |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BA_W | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| req_mask_i | input | MASK_W | Byte mask, 1 = byte disabled |
| req_wdata_i | input | DATA_W | Write data |
| req_ack_o | output | 1 | Request accepted this cycle |
| rd_valid_o | output | 1 | Read data valid strobe |
| rd_data_o | output | DATA_W | Read data |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | BA_W | Bank address |
| sd_addr_o | output | ROW_W | Row/column address with auto-precharge bit |
| sd_dqm_o | output | MASK_W | Byte mask to memory |
| sd_dq_o | output | DATA_W | Write data to memory |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dq_i | input | DATA_W | Read data from memory |

## Verification
A stale or wrong open-row record shows up as soon as the host next touches that bank. The result is one of three faults, all visible in the cycle after the acknowledge:
- an activate to a bank that is already open;
- a column command to a closed bank;
- a precharge where none was due.

A wait counter that is off by one moves the activate, column command or read strobe by a cycle relative to the acknowledge. It can also shift the next acknowledge after a write. The bench therefore checks each command's offset from its own acknowledge and each read strobe's exact cycle. A refresh record that is not cleared shows at the following access, which would wrongly skip or add the precharge.

// File: rtl/sdram_bank_pkg.sv
package sdram_bank_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_ACT  = 4'b0011,
    CMD_WRIT = 4'b0100,
    CMD_READ = 4'b0101,
    CMD_NOP  = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HNOP, S_PRE, S_TRP, S_ACT, S_RCD, S_COL,
    S_RDW, S_WREC, S_PALL, S_RTRP, S_REF, S_RFCW
  } ctrl_state_e;

endpackage

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker #(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 12,
  parameter int BA_W      = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_set_i,
  input  logic             close_i,
  input  logic             close_all_i,
  input  logic [BA_W-1:0]  upd_bank_i,
  input  logic [ROW_W-1:0] upd_row_i,
  input  logic [BA_W-1:0]  lk_bank_i,
  input  logic [ROW_W-1:0] lk_row_i,
  output logic             lk_open_o,
  output logic             lk_hit_o
);

  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (upd_bank_i == BA_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (close_all_i || (close_i && sel)) begin
        open_q[b] <= 1'b0;
      end else if (open_set_i && sel) begin
        open_q[b] <= 1'b1;
        row_q[b]  <= upd_row_i;
      end
    end
  end

  assign lk_open_o = open_q[lk_bank_i];
  assign lk_hit_o  = (row_q[lk_bank_i] == lk_row_i);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REF_INTERVAL = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic served_i,
  output logic pending_o
);

  localparam int CW = $clog2(REF_INTERVAL + 1);

  logic [CW-1:0] cnt_q;
  logic          due;

  assign due = (cnt_q == CW'(REF_INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pending_o <= 1'b0;
    end else begin
      cnt_q <= due ? '0 : cnt_q + 1'b1;
      if (due)           pending_o <= 1'b1;
      else if (served_i) pending_o <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_bank_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int MASK_W = 2,
  parameter int BA_W   = 1,
  parameter int AP_BIT = 10
) (
  input  ctrl_state_e       state_i,
  input  logic              wr_i,
  input  logic              open_row_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [MASK_W-1:0] dqm_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);

  sd_cmd_e cmd;

  always_comb begin
    cmd     = CMD_NOP;
    ba_o    = ba_i;
    addr_o  = '0;
    dq_o    = '0;
    dq_oe_o = 1'b0;
    dqm_o   = mask_i;
    unique case (state_i)
      S_IDLE, S_PALL, S_RTRP, S_REF, S_RFCW: dqm_o = '1;
      default: ;
    endcase
    unique case (state_i)
      S_PRE: cmd = CMD_PRE;
      S_ACT: begin
        cmd    = CMD_ACT;
        addr_o = row_i;
      end
      S_COL: begin
        cmd                 = wr_i ? CMD_WRIT : CMD_READ;
        addr_o[COL_W-1:0]   = col_i;
        addr_o[AP_BIT]      = !open_row_i;
        if (wr_i) begin
          dq_o    = wdata_i;
          dq_oe_o = 1'b1;
        end
      end
      S_PALL: begin
        cmd            = CMD_PRE;
        ba_o           = '0;
        addr_o[AP_BIT] = 1'b1;
      end
      S_REF: begin
        cmd  = CMD_REF;
        ba_o = '0;
      end
      default: ;
    endcase
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;

endmodule

// File: rtl/sdram_bank_ctrl.sv
module sdram_bank_ctrl
  import sdram_bank_pkg::*;
#(
  parameter int NUM_BANKS    = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 16,
  parameter int MASK_W       = DATA_W / 8,
  parameter int AP_BIT       = 10,
  parameter int T_RCD        = 2,
  parameter int CAS_LAT      = 2,
  parameter int T_RWL        = 1,
  parameter int T_AP         = 2,
  parameter int T_RFC        = 4,
  parameter int REF_INTERVAL = 780,
  parameter int BA_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_row_i,
  input  logic              trp_sel_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [BA_W-1:0]   req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [MASK_W-1:0] req_mask_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ack_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic [BA_W-1:0]   sd_ba_o,
  output logic [ROW_W-1:0]  sd_addr_o,
  output logic [MASK_W-1:0] sd_dqm_o,
  output logic [DATA_W-1:0] sd_dq_o,
  output logic              sd_dq_oe_o,
  input  logic [DATA_W-1:0] sd_dq_i
);

  localparam int T_WGAP   = T_RWL + T_AP;
  localparam int MAX_A    = (T_RCD > CAS_LAT) ? T_RCD : CAS_LAT;
  localparam int MAX_B    = (T_WGAP > T_RFC) ? T_WGAP : T_RFC;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  ctrl_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_q;
  logic [BA_W-1:0]   ba_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [MASK_W-1:0] mask_q;
  logic [DATA_W-1:0] wdata_q;
  logic              take, capture;
  logic              trk_set, trk_close, trk_close_all;
  logic              lk_open, lk_hit;
  logic              ref_pend, ref_served;

  assign take      = (state_q == S_IDLE) && !ref_pend && req_valid_i;
  assign req_ack_o = take;

  always_comb begin
    state_d       = state_q;
    cnt_d         = cnt_q;
    trk_set       = 1'b0;
    trk_close     = 1'b0;
    trk_close_all = 1'b0;
    ref_served    = 1'b0;
    capture       = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (ref_pend)                             state_d = S_PALL;
        else if (req_valid_i) begin
          if (lk_open && lk_hit && open_row_i)    state_d = req_write_i ? S_COL : S_HNOP;
          else if (lk_open)                       state_d = S_PRE;
          else                                    state_d = S_ACT;
        end
      end
      S_HNOP: state_d = S_COL;
      S_PRE: begin
        trk_close = 1'b1;
        state_d   = trp_sel_i ? S_TRP : S_ACT;
      end
      S_TRP: state_d = S_ACT;
      S_ACT: begin
        trk_set = 1'b1;
        if (T_RCD <= 1) state_d = S_COL;
        else begin
          state_d = S_RCD;
          cnt_d   = CNT_W'(T_RCD - 2);
        end
      end
      S_RCD: begin
        if (cnt_q == '0) state_d = S_COL;
        else             cnt_d   = cnt_q - 1'b1;
      end
      S_COL: begin
        trk_close = !open_row_i;
        if (!wr_q) begin
          state_d = S_RDW;
          cnt_d   = CNT_W'(CAS_LAT - 1);
        end else if (open_row_i) begin
          state_d = S_IDLE;
        end else begin
          state_d = S_WREC;
          cnt_d   = CNT_W'(T_WGAP - 1);
        end
      end
      S_RDW: begin
        if (cnt_q == '0) begin
          capture = 1'b1;
          state_d = S_IDLE;
        end else cnt_d = cnt_q - 1'b1;
      end
      S_WREC: begin
        if (cnt_q == '0) state_d = S_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      S_PALL: begin
        trk_close_all = 1'b1;
        state_d       = trp_sel_i ? S_RTRP : S_REF;
      end
      S_RTRP: state_d = S_REF;
      S_REF: begin
        ref_served = 1'b1;
        state_d    = S_RFCW;
        cnt_d      = CNT_W'(T_RFC - 1);
      end
      S_RFCW: begin
        if (cnt_q == '0) state_d = S_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      wr_q       <= 1'b0;
      ba_q       <= '0;
      row_q      <= '0;
      col_q      <= '0;
      mask_q     <= '0;
      wdata_q    <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      rd_valid_o <= capture;
      if (capture) rd_data_o <= sd_dq_i;
      if (take) begin
        wr_q    <= req_write_i;
        ba_q    <= req_bank_i;
        row_q   <= req_row_i;
        col_q   <= req_col_i;
        mask_q  <= req_mask_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  sdram_row_tracker #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BA_W(BA_W)
  ) u_tracker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .open_set_i  (trk_set),
    .close_i     (trk_close),
    .close_all_i (trk_close_all),
    .upd_bank_i  (ba_q),
    .upd_row_i   (row_q),
    .lk_bank_i   (req_bank_i),
    .lk_row_i    (req_row_i),
    .lk_open_o   (lk_open),
    .lk_hit_o    (lk_hit)
  );

  sdram_refresh_timer #(
    .REF_INTERVAL(REF_INTERVAL)
  ) u_refresh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .served_i  (ref_served),
    .pending_o (ref_pend)
  );

  sdram_cmd_drive #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .MASK_W(MASK_W), .BA_W(BA_W), .AP_BIT(AP_BIT)
  ) u_drive (
    .state_i    (state_q),
    .wr_i       (wr_q),
    .open_row_i (open_row_i),
    .ba_i       (ba_q),
    .row_i      (row_q),
    .col_i      (col_q),
    .mask_i     (mask_q),
    .wdata_i    (wdata_q),
    .cs_n_o     (sd_cs_n_o),
    .ras_n_o    (sd_ras_n_o),
    .cas_n_o    (sd_cas_n_o),
    .we_n_o     (sd_we_n_o),
    .ba_o       (sd_ba_o),
    .addr_o     (sd_addr_o),
    .dqm_o      (sd_dqm_o),
    .dq_o       (sd_dq_o),
    .dq_oe_o    (sd_dq_oe_o)
  );

endmodule

// File: rtl/sdram_bank_ctrl_sva.sv
module sdram_bank_ctrl_sva #(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 12,
  parameter int AP_BIT    = 10,
  parameter int BA_W      = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             open_row_i,
  input logic             trp_sel_i,
  input logic             req_valid_i,
  input logic             req_ack_o,
  input logic             rd_valid_o,
  input logic             sd_cs_n_o,
  input logic             sd_ras_n_o,
  input logic             sd_cas_n_o,
  input logic             sd_we_n_o,
  input logic [BA_W-1:0]  sd_ba_o,
  input logic [ROW_W-1:0] sd_addr_o,
  input logic             sd_dq_oe_o
);

  logic [3:0] cmd;
  logic       is_act, is_col, is_pre1, is_pall, is_ref, is_nop, a10;
  logic [NUM_BANKS-1:0] open_m;

  assign cmd     = {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o};
  assign a10     = sd_addr_o[AP_BIT];
  assign is_act  = (cmd == 4'b0011);
  assign is_col  = (cmd == 4'b0101) || (cmd == 4'b0100);
  assign is_pre1 = (cmd == 4'b0010) && !a10;
  assign is_pall = (cmd == 4'b0010) && a10;
  assign is_ref  = (cmd == 4'b0001);
  assign is_nop  = (cmd == 4'b0111);

  // bank state rebuilt from the command pins only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_m <= '0;
    else if (is_pall) open_m <= '0;
    else if (is_act) open_m[sd_ba_o] <= 1'b1;
    else if (is_pre1 || (is_col && a10)) open_m[sd_ba_o] <= 1'b0;
  end

  p_cmd_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_nop || is_act || is_col || is_pre1 || is_pall || is_ref);

  p_col_ap_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> (a10 == !open_row_i));

  p_col_open_bank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> open_m[sd_ba_o]);

  p_act_closed_bank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> !open_m[sd_ba_o]);

  p_pre_act_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pre1 && !trp_sel_i) |=> (is_act && sd_ba_o == $past(sd_ba_o)));

  p_pre_gap_two_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pre1 && trp_sel_i) |=> is_nop);

  p_pall_ref_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pall && !trp_sel_i) |=> is_ref);

  p_oe_only_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_dq_oe_o |-> (cmd == 4'b0100));

  p_rd_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  p_ack_valid_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o |-> req_valid_i);

  p_ack_single_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o |=> !req_ack_o);

endmodule

bind sdram_bank_ctrl sdram_bank_ctrl_sva #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .AP_BIT(AP_BIT), .BA_W(BA_W)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .open_row_i  (open_row_i),
  .trp_sel_i   (trp_sel_i),
  .req_valid_i (req_valid_i),
  .req_ack_o   (req_ack_o),
  .rd_valid_o  (rd_valid_o),
  .sd_cs_n_o   (sd_cs_n_o),
  .sd_ras_n_o  (sd_ras_n_o),
  .sd_cas_n_o  (sd_cas_n_o),
  .sd_we_n_o   (sd_we_n_o),
  .sd_ba_o     (sd_ba_o),
  .sd_addr_o   (sd_addr_o),
  .sd_dq_oe_o  (sd_dq_oe_o)
);

// File: tb/sdram_bank_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_bank_ctrl_bench;

  localparam int ROW_W = 12, COL_W = 8, DATA_W = 16, MASK_W = 2, BA_W = 1;
  localparam int T_RCD = 2, CAS_LAT = 2, T_RWL = 1, T_AP = 2, T_RFC = 3;
  localparam int REF_IV = 400;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic open_row = 1'b0, trp_sel = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [BA_W-1:0]   req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [MASK_W-1:0] req_mask = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ack, rd_valid, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [DATA_W-1:0] rd_data, dq_o;
  logic [DATA_W-1:0] dq_i = '0;
  logic [BA_W-1:0]   ba;
  logic [ROW_W-1:0]  addr;
  logic [MASK_W-1:0] dqm;

  always #2.5 clk = ~clk;

  sdram_bank_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .CAS_LAT(CAS_LAT), .T_RWL(T_RWL), .T_AP(T_AP), .T_RFC(T_RFC),
    .REF_INTERVAL(REF_IV)
  ) u_sdram_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .open_row_i(open_row), .trp_sel_i(trp_sel),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_bank_i(req_bank),
    .req_row_i(req_row), .req_col_i(req_col), .req_mask_i(req_mask),
    .req_wdata_i(req_wdata), .req_ack_o(req_ack), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n),
    .sd_cas_n_o(cas_n), .sd_we_n_o(we_n), .sd_ba_o(ba), .sd_addr_o(addr),
    .sd_dqm_o(dqm), .sd_dq_o(dq_o), .sd_dq_oe_o(dq_oe), .sd_dq_i(dq_i)
  );

  typedef struct {
    logic [3:0] cmd;
    int ba, a10, addr, off, mask, data;
    string req;
  } cmd_item_t;

  typedef struct { int data; int due; } rd_item_t;

  cmd_item_t cq[$];
  rd_item_t  rq[$];

  int checks = 0, errors = 0, cyc = 0, ack_cyc = 0;
  int m_open[2] = '{0, 0};
  int m_row[2]  = '{0, 0};
  int mem_row[2] = '{0, 0};
  int pall_cyc = -1, last_ref = -1, ref_count = 0;
  int rd_due = -1, rd_val = 0;
  int prev_col = 0, prev_wr = 0, prev_auto = 0, prev_refs = 0;
  logic [MASK_W-1:0] prev_dqm = '1;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int mem_val(int b, int r, int c);
    return (b * 16'h4000 + r * 37 + c * 5 + 16'h1111) & 16'hffff;
  endfunction

  function automatic cmd_item_t mk(logic [3:0] c, int b, int a10, int ad, int off,
                                   int mask, int data, string req);
    cmd_item_t it;
    it.cmd = c; it.ba = b; it.a10 = a10; it.addr = ad; it.off = off;
    it.mask = mask; it.data = data; it.req = req;
    return it;
  endfunction

  // driver: presents a request, waits for acceptance, queues expectations
  task automatic do_req(input bit wr, input int b, input int r, input int c,
                        input int mask, input int data, input bit b2b);
    int col_off, base, trp;
    string rq_tag;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bank = BA_W'(b); req_row = ROW_W'(r);
    req_col = COL_W'(c); req_mask = MASK_W'(mask); req_wdata = DATA_W'(data);
    while (1) begin
      #1;
      if (req_ack) break;
      @(negedge clk);
    end
    ack_cyc = cyc;
    trp = trp_sel ? 2 : 1;
    if (b2b && prev_wr && ref_count == prev_refs)
      chk((ack_cyc - prev_col) == (prev_auto ? 1 + T_RWL + T_AP : 1), "R9",
          "ack after write", ack_cyc - prev_col, prev_auto ? 1 + T_RWL + T_AP : 1);
    if (m_open[b] && m_row[b] == r && open_row) begin
      col_off = wr ? 1 : 2;
      rq_tag = wr ? "R4" : "R5";
    end else begin
      base = 1;
      rq_tag = open_row ? "R8" : "R2";
      if (m_open[b]) begin
        cq.push_back(mk(C_PRE, b, 0, 0, 1, 0, 0, "R6"));
        base = 1 + trp;
        rq_tag = "R6";
      end
      cq.push_back(mk(C_ACT, b, 0, r, base, 0, 0, rq_tag));
      col_off = base + T_RCD;
    end
    cq.push_back(mk(wr ? C_WR : C_RD, b, open_row ? 0 : 1, c, col_off, mask, data,
                    open_row ? "R3" : "R2"));
    if (!wr) rq.push_back('{mem_val(b, r, c), ack_cyc + col_off + CAS_LAT + 1});
    m_open[b] = open_row;
    m_row[b]  = r;
    prev_col  = ack_cyc + col_off;
    prev_wr   = wr;
    prev_auto = !open_row;
    prev_refs = ref_count;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: memory model, command and read-data scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] c;
      cmd_item_t e;
      rd_item_t d;
      c = {cs_n, ras_n, cas_n, we_n};
      if (req_ack && !req_valid) chk(0, "R13", "ack without valid", 1, 0);
      if (dq_oe && c != C_WR) chk(0, "R11", "oe outside write", 1, 0);
      if (c == C_PRE && addr[10]) begin
        pall_cyc = cyc;
      end else if (c == C_REF) begin
        chk(cyc - pall_cyc == (trp_sel ? 2 : 1), "R12", "pall to ref gap",
            cyc - pall_cyc, trp_sel ? 2 : 1);
        if (last_ref >= 0)
          chk((cyc - last_ref) >= REF_IV - 24 && (cyc - last_ref) <= REF_IV + 24,
              "R12", "refresh interval", cyc - last_ref, REF_IV);
        last_ref = cyc;
        ref_count++;
        m_open[0] = 0; m_open[1] = 0;
      end else if (c != C_NOP) begin
        if (cq.size() == 0) chk(0, "R1", "unexpected command", int'(c), int'(C_NOP));
        else begin
          e = cq.pop_front();
          chk(c == e.cmd, e.req, "command", int'(c), int'(e.cmd));
          chk(int'(ba) == e.ba, e.req, "bank", int'(ba), e.ba);
          chk(cyc - ack_cyc == e.off, e.req, "offset from ack", cyc - ack_cyc, e.off);
          if (e.cmd == C_ACT) chk(int'(addr) == e.addr, e.req, "row", int'(addr), e.addr);
          else if (e.cmd == C_PRE) chk(addr[10] == 1'b0, "R6", "single-bank bit", int'(addr[10]), 0);
          else begin
            chk(int'(addr[COL_W-1:0]) == e.addr, e.req, "column", int'(addr[COL_W-1:0]), e.addr);
            chk(int'(addr[10]) == e.a10, e.req, "auto-precharge bit", int'(addr[10]), e.a10);
          end
          if (e.cmd == C_WR) begin
            chk(int'(dq_o) == e.data && dq_oe, "R11", "write data", int'(dq_o), e.data);
            chk(int'(dqm) == e.mask, "R11", "write mask", int'(dqm), e.mask);
          end
          if (e.cmd == C_RD) begin
            chk(int'(dqm) == e.mask, "R5", "mask at read", int'(dqm), e.mask);
            chk(int'(prev_dqm) == e.mask, "R5", "mask before read", int'(prev_dqm), e.mask);
          end
        end
      end
      if (c == C_ACT) mem_row[ba] = int'(addr);
      if (c == C_RD) begin
        rd_due = cyc + CAS_LAT;
        rd_val = mem_val(int'(ba), mem_row[ba], int'(addr[COL_W-1:0]));
      end
      dq_i = (cyc == rd_due) ? DATA_W'(rd_val) : '0;
      if (rd_valid) begin
        if (rq.size() == 0) chk(0, "R10", "unexpected read strobe", 1, 0);
        else begin
          d = rq.pop_front();
          chk(int'(rd_data) == d.data, "R10", "read data", int'(rd_data), d.data);
          chk(cyc == d.due, "R10", "read strobe cycle", cyc, d.due);
        end
      end
      prev_dqm = dqm;
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    chk(0, "R13", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1", "reset command", int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
    chk(dqm == '1 && !dq_oe, "R1", "reset mask/oe", int'(dqm), 3);
    chk(!req_ack && !rd_valid, "R13", "reset ack/strobe", int'(req_ack), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // auto-precharge mode: R2, R9
    do_req(1, 0, 3, 10, 0, 16'hA5A5, 0);
    do_req(1, 0, 3, 11, 1, 16'h5A5A, 1);
    do_req(0, 0, 3, 10, 2, 0, 0);
    idle(6);

    // open-row mode: R3, R4, R5, R6, R8, R9
    open_row = 1;
    do_req(0, 0, 5, 1, 0, 0, 0);
    do_req(0, 0, 5, 2, 2, 0, 0);
    do_req(1, 0, 5, 3, 1, 16'h1234, 0);
    do_req(1, 0, 5, 4, 0, 16'h4321, 1);
    do_req(0, 1, 9, 7, 0, 0, 0);
    do_req(0, 0, 6, 8, 1, 0, 0);
    idle(4);
    trp_sel = 1;   // R7
    do_req(1, 1, 2, 9, 2, 16'hBEEF, 0);
    do_req(0, 1, 2, 9, 0, 0, 0);
    do_req(0, 0, 5, 3, 0, 0, 0);

    // refresh: R12
    idle(900);
    do_req(0, 0, 6, 0, 0, 0, 0);
    trp_sel = 0;
    for (int i = 0; i < 120; i++)
      do_req(i % 3 == 0, i % 2, (i / 4) % 3, i, i % 4, i * 3, 0);

    // leaving open-row mode with a bank open: R6
    idle(6);
    open_row = 0;
    do_req(1, 0, 1, 1, 0, 16'h0F0F, 0);
    do_req(0, 1, 1, 2, 0, 0, 0);
    idle(30);
    chk(cq.size() == 0, "R2", "pending commands", cq.size(), 0);
    chk(rq.size() == 0, "R10", "pending reads", rq.size(), 0);
    chk(ref_count >= 2, "R12", "refresh count", ref_count, 2);
    finish_run();
  end

endmodule